// File: doc/BRIEF.md
# Address search triplet unit

This block carries out one step of the binary address search on a single-wire bus. After a start strobe it asks an external slot engine for two read slots. The first returns the address bit of all responding devices and the second returns its complement. From that pair and a preferred direction it picks the branch to follow. It then asks for one write slot that sends the chosen direction back to the devices. It ends the step with a one-cycle done pulse and a packed 3-bit status code.

The slot engine is reached through a request/acknowledge pair. `slot_go` pulses for one cycle with `slot_write` selecting a read slot (0) or a write slot (1) and `slot_wval` carrying the bit to write. The engine answers with a one-cycle `slot_ack`, and for a read slot the bus level comes with it on `slot_rval`. The search loop that walks the address bits and tracks discrepancies lives outside this block and calls it once per bit.

Top module: `trip_unit`

## Requirements
- R1: While reset is held and right after it, busy, done, slot_go and status are all 0.
- R2: A start seen while idle makes busy go high, and slot_go pulses in the next cycle with slot_write = 0 (a read slot for the address bit).
- R3: The second read slot (complement bit) and the write slot are each requested exactly one cycle after the acknowledge of the slot before them. Only one slot is outstanding at any time.
- R4: The status code packs status[0] = address bit read, status[1] = complement bit read, status[2] = direction taken.
- R5: When both read bits are 1, status is 3 (binary 011), no write slot is requested, and done pulses one cycle after the second read acknowledge.
- R6: When both read bits are 0, the direction is the pref_dir value captured with the accepted start. Status is 4 for direction 1 and 0 for direction 0.
- R7: When exactly one read bit is 1, the direction follows the address bit, whatever pref_dir is. Status is 5 (address bit 1) or 2 (address bit 0).
- R8: In every non-error case a single write slot is requested with slot_wval equal to status[2], and done pulses one cycle after that slot's acknowledge.
- R9: done lasts one cycle, and status changes only in a cycle where done is high. It then holds its value until the next step completes.
- R10: A start arriving while busy is ignored. It changes neither the slot sequence, the captured direction nor the status, and starts no further step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one search step (accepted only when idle) |
| pref_dir | input | 1 | Direction to take when both read bits are 0 |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle pulse when the step ends |
| status | output | 3 | Packed result: {direction, complement bit, address bit} |
| slot_go | output | 1 | One-cycle request to the slot engine |
| slot_write | output | 1 | Slot kind: 0 read, 1 write |
| slot_wval | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | Slot engine finished the requested slot |
| slot_rval | input | 1 | Bus level sampled in a read slot, valid with slot_ack |

## Verification
The bench builds the unit with its default setting LATCH_PREF = 1, so the preferred direction is captured when a start is accepted. This lets the bench flip pref_dir mid-step, or offer an ignored second start with the opposite direction, and still expect the value it gave at the start. The slot engine model answers after a latency that varies per step. That makes it possible to check the one-cycle turnaround between an acknowledge and the next request, or the done pulse, at more than one spacing. All four read-bit combinations are run with both preferred directions.

// File: rtl/trip_pkg.sv
package trip_pkg;

   localparam int unsigned CODE_W  = 3;
   localparam int unsigned BIT_ID  = 0;
   localparam int unsigned BIT_CP  = 1;
   localparam int unsigned BIT_DIR = 2;

   typedef logic [CODE_W-1:0] trip_code_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ID_REQ,
      ST_ID_WAIT,
      ST_CP_REQ,
      ST_CP_WAIT,
      ST_WR_REQ,
      ST_WR_WAIT,
      ST_FIN
   } trip_state_t;

endpackage

// File: rtl/trip_decide.sv
module trip_decide
   import trip_pkg::*;
(
   input  logic       id_bit,
   input  logic       cp_bit,
   input  logic       pref,
   output logic       abort,
   output trip_code_t code
);

   logic dir;

   always_comb begin
      abort = id_bit & cp_bit;
      // a single responding polarity forces the branch; otherwise use the preference
      dir   = (id_bit ^ cp_bit) ? id_bit : pref;
      code  = '0;
      code[BIT_ID]  = id_bit;
      code[BIT_CP]  = cp_bit;
      code[BIT_DIR] = dir & ~abort;
   end

endmodule

// File: rtl/trip_seq.sv
module trip_seq
   import trip_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic slot_ack,
   input  logic slot_rval,
   input  logic abort,
   output logic accept,
   output logic id_bit,
   output logic cp_take,
   output logic fin_load,
   output logic slot_go,
   output logic slot_write,
   output logic busy,
   output logic done
);

   trip_state_t state_q, state_d;
   logic        id_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start)    state_d = ST_ID_REQ;
         ST_ID_REQ:                state_d = ST_ID_WAIT;
         ST_ID_WAIT: if (slot_ack) state_d = ST_CP_REQ;
         ST_CP_REQ:                state_d = ST_CP_WAIT;
         ST_CP_WAIT: if (slot_ack) state_d = abort ? ST_FIN : ST_WR_REQ;
         ST_WR_REQ:                state_d = ST_WR_WAIT;
         ST_WR_WAIT: if (slot_ack) state_d = ST_FIN;
         ST_FIN:                   state_d = ST_IDLE;
         default:                  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         id_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_ID_WAIT && slot_ack) id_q <= slot_rval;
      end
   end

   always_comb begin
      accept     = (state_q == ST_IDLE) && start;
      cp_take    = (state_q == ST_CP_WAIT) && slot_ack;
      fin_load   = (cp_take && abort) || ((state_q == ST_WR_WAIT) && slot_ack);
      slot_go    = (state_q == ST_ID_REQ) || (state_q == ST_CP_REQ) ||
                   (state_q == ST_WR_REQ);
      slot_write = (state_q == ST_WR_REQ);
      busy       = (state_q != ST_IDLE);
      done       = (state_q == ST_FIN);
      id_bit     = id_q;
   end

endmodule

// File: rtl/trip_status.sv
module trip_status
   import trip_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cp_take,
   input  logic       fin_load,
   input  trip_code_t code_in,
   output logic       dir,
   output trip_code_t status
);

   trip_code_t result_q, status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         status_q <= '0;
      end else begin
         if (cp_take)  result_q <= code_in;
         if (fin_load) status_q <= cp_take ? code_in : result_q;
      end
   end

   assign dir    = result_q[BIT_DIR];
   assign status = status_q;

endmodule

// File: rtl/trip_unit.sv
module trip_unit
   import trip_pkg::*;
#(
   parameter bit LATCH_PREF = 1'b1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       pref_dir,
   output logic       busy,
   output logic       done,
   output logic [2:0] status,
   output logic       slot_go,
   output logic       slot_write,
   output logic       slot_wval,
   input  logic       slot_ack,
   input  logic       slot_rval
);

   if (CODE_W != 3) begin : g_bad_width
      $error("trip_unit: status code must be 3 bits wide");
   end

   logic       accept, id_bit, cp_take, fin_load, abort, pref_sel;
   trip_code_t code;

   if (LATCH_PREF) begin : g_pref_latched
      logic pref_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pref_q <= 1'b0;
         else if (accept) pref_q <= pref_dir;
      end
      assign pref_sel = pref_q;
   end else begin : g_pref_live
      assign pref_sel = pref_dir;
   end

   trip_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .slot_ack   (slot_ack),
      .slot_rval  (slot_rval),
      .abort      (abort),
      .accept     (accept),
      .id_bit     (id_bit),
      .cp_take    (cp_take),
      .fin_load   (fin_load),
      .slot_go    (slot_go),
      .slot_write (slot_write),
      .busy       (busy),
      .done       (done)
   );

   trip_decide u_decide (
      .id_bit (id_bit),
      .cp_bit (slot_rval),
      .pref   (pref_sel),
      .abort  (abort),
      .code   (code)
   );

   trip_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .cp_take  (cp_take),
      .fin_load (fin_load),
      .code_in  (code),
      .dir      (slot_wval),
      .status   (status)
   );

endmodule

// File: rtl/trip_unit_chk.sv
module trip_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic [2:0] status,
   input logic       slot_go,
   input logic       slot_write,
   input logic       slot_wval
);

   logic [2:0] go_cnt_q;
   logic       last_wval_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_cnt_q    <= '0;
         last_wval_q <= 1'b0;
      end else begin
         if (start && !busy)  go_cnt_q <= '0;
         else if (slot_go)    go_cnt_q <= go_cnt_q + 3'd1;
         if (slot_go && slot_write) last_wval_q <= slot_wval;
      end
   end

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_go |=> !slot_go);

   // R5
   slot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((status == 3'd3) ? (go_cnt_q == 3'd2) : (go_cnt_q == 3'd3)));

   // R8
   wdir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status != 3'd3) |-> (status[2] == last_wval_q));

   // R9
   status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(status));

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

endmodule

bind trip_unit trip_unit_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .status     (status),
   .slot_go    (slot_go),
   .slot_write (slot_write),
   .slot_wval  (slot_wval)
);

// File: tb/sim_trip_unit.sv
module sim_trip_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       pref_dir = 1'b0;
   logic       busy, done, slot_go, slot_write, slot_wval;
   logic [2:0] status;
   logic       slot_ack = 1'b0;
   logic       slot_rval = 1'b0;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   // engine model state
   bit  e_id, e_cp;
   int  e_lat = 1;
   int  rd_cnt, wr_cnt, go_total, go_in_step;
   bit  wval_seen;
   longint cyc = 0, ack_cyc = 0;
   bit  done_seen;
   logic [2:0] exp_q[$];

   always #4 clk = ~clk;   // 125 MHz

   trip_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
      .busy(busy), .done(done), .status(status),
      .slot_go(slot_go), .slot_write(slot_write), .slot_wval(slot_wval),
      .slot_ack(slot_ack), .slot_rval(slot_rval)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [2:0] model(input bit id, input bit cp, input bit pf);
      if (id && cp)        return 3'd3;
      else if (!id && !cp) return pf ? 3'd4 : 3'd0;
      else if (id)         return 3'd5;
      else                 return 3'd2;
   endfunction

   // slot engine model
   initial begin
      forever begin
         @(negedge clk);
         while (slot_go) begin
            bit rv;
            go_total++;
            if (go_in_step > 0)  // R3: one-cycle turnaround after an acknowledge
               chk(cyc - ack_cyc == 1, "R3 request gap", cyc - ack_cyc, 1);
            go_in_step++;
            rv = 1'b0;
            if (!slot_write) begin
               rv = (rd_cnt == 0) ? e_id : e_cp;
               rd_cnt++;
            end else begin
               wr_cnt++;
               wval_seen = slot_wval;
            end
            repeat (e_lat) @(negedge clk);
            slot_ack  = 1'b1;
            slot_rval = rv;
            ack_cyc   = cyc;
            @(negedge clk);
            slot_ack  = 1'b0;
            slot_rval = 1'b0;
         end
      end
   end

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            logic [2:0] e;
            if (exp_q.size() == 0) begin
               chk(0, "R9 unexpected done", 1, 0);
            end else begin
               e = exp_q.pop_front();
               chk(status == e, "R4 status", status, e);
               chk(rd_cnt == 2, "R3 read slots", rd_cnt, 2);
               chk(wr_cnt == ((e == 3'd3) ? 0 : 1), "R5/R8 write slots", wr_cnt,
                   (e == 3'd3) ? 0 : 1);
               if (e != 3'd3) chk(wval_seen == e[2], "R8 write value", wval_seen, e[2]);
               chk(cyc - ack_cyc == 1, "R8 done timing", cyc - ack_cyc, 1);
            end
            done_seen = 1;
         end
      end
   end

   task automatic run_trip(input bit id, input bit cp, input bit pf, input int lat,
                           input bit poke, input bit flip, input string req);
      logic [2:0] e;
      int         g0;
      e = model(id, cp, pf);
      e_id = id; e_cp = cp; e_lat = lat;
      rd_cnt = 0; wr_cnt = 0; go_in_step = 0; done_seen = 0;
      exp_q.push_back(e);
      @(negedge clk);
      start = 1'b1; pref_dir = pf;
      @(negedge clk);
      start = 1'b0;
      // R2: first request is a read slot one cycle after the start is taken
      chk(slot_go && !slot_write && busy, "R2 first read request",
          {busy, slot_go, slot_write}, 3'b110);
      if (flip) pref_dir = ~pf;
      if (poke) begin
         // R10: second start while busy, opposite preference
         repeat (2) @(negedge clk);
         start = 1'b1; pref_dir = ~pf;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      g0 = go_total;
      repeat (4) begin
         @(negedge clk);
         // R9 status holds, done is a single pulse
         chk(status == e && !done, "R9 hold", status, e);
         chk(!busy && go_total == g0, "R10 no further step", go_total, g0);
      end
      $display("step %s done", req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !slot_go && status == 3'd0, "R1 in reset",
          {busy, done, slot_go, status}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !slot_go && status == 3'd0, "R1 after reset",
          {busy, done, slot_go, status}, 0);

      run_trip(0, 0, 0, 1, 0, 0, "R6 pref0");
      run_trip(0, 0, 1, 2, 0, 0, "R6 pref1");
      run_trip(1, 0, 0, 3, 0, 0, "R7 id1 pref0");
      run_trip(1, 0, 1, 1, 0, 0, "R7 id1 pref1");
      run_trip(0, 1, 1, 2, 0, 0, "R7 id0 pref1");
      run_trip(0, 1, 0, 4, 0, 0, "R7 id0 pref0");
      run_trip(1, 1, 0, 1, 0, 0, "R5 abort");
      run_trip(1, 1, 1, 3, 0, 0, "R5 abort pref1");
      run_trip(0, 0, 1, 2, 0, 1, "R6 pref flipped after start");
      run_trip(0, 0, 1, 3, 1, 0, "R10 start while busy");
      run_trip(0, 0, 0, 2, 1, 1, "R10 start while busy pref0");
      run_trip(1, 0, 0, 1, 1, 0, "R7 after ignored start");

      chk(exp_q.size() == 0, "R9 pending results", exp_q.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule